// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block is the command side of a NOR-style flash device. It watches a host bus made of an asynchronous active-low write strobe, an address and a data byte. From those writes it picks out the erase command sequences. The strobe is brought into the system clock domain through a two-stage synchroniser. A command is taken once per rising edge of the strobe, using the address and data held on the bus at that moment.

The normal path needs six writes. First come two unlock writes, then an erase setup write, then two more unlock writes, and last the erase code. That code is either a whole-array erase, or a sector erase whose target sector comes from the upper address bits. A sector erase first opens a collection window. During the window more sector-erase writes add sectors and restart the window. Any other write cancels the request.

A three-write entry sequence switches the decoder into a bypass mode. In that mode an erase needs only the setup write and the erase code. The erase engine is a counter stub. It holds the busy output high for a fixed number of clocks and then pulses a done output. While the engine runs, every write is ignored. A hardware reset input stops any operation at once. A zero-prefill before erase is part of the engine interval and needs no host action.

Top module: `eraseCmdDecoder`

## Requirements
- R1: After reset, busy, pending, bypassOn and eraseDone are 0 and sectMask is all zero.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h, with addresses compared on busAddr[10:0], start a whole-array erase. busy rises and sectMask becomes all ones.
- R3: The same five-write prefix followed by 30h at any address opens the sector window. pending is 1 and sectMask has only the bit selected by busAddr[ADDR_W-1:11]. When the window expires with no further write, busy rises with that mask.
- R4: During the window, a write of 30h adds its sector to sectMask and restarts the window. Any other data value ends the request, clears sectMask and starts no erase.
- R5: AAh@555h, 55h@2AAh, 20h@555h sets bypassOn. In bypass mode, 80h followed by 10h (any address) starts a whole-array erase, and 80h followed by 30h starts a sector request. 90h followed by 00h leaves bypass mode.
- R6: While busy is high, writes have no effect: sectMask stays unchanged, the run length is unchanged, and no new operation follows the run.
- R7: busy stays high for exactly ERASE_CYC clocks. The run ends with a one-clock eraseDone pulse, and at that point busy is 0 and sectMask is zero.
- R8: With hwRstN low at a clock edge, the next cycle shows busy, pending, bypassOn, eraseDone at 0 and sectMask at zero. An interrupted erase never pulses eraseDone.
- R9: A write that breaks an unfinished sequence returns the decoder to read mode without starting anything. A correct sequence afterwards works normally.
- R10: A command acts only on the rising edge of weN. While weN is held low, the final erase code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset, asynchronous |
| hwRstN | input | 1 | Active-low hardware reset pin, sampled on clk |
| weN | input | 1 | Asynchronous active-low write strobe |
| busAddr | input | ADDR_W | Write address: sector index in the top bits, command address in [10:0] |
| busData | input | 8 | Write data byte |
| busy | output | 1 | Erase engine running |
| pending | output | 1 | Sector collection window open |
| bypassOn | output | 1 | Shortened command mode active |
| eraseDone | output | 1 | One-clock pulse when an erase finishes |
| sectMask | output | NSECT | Sectors targeted by the current request |

## Verification
The hardest situations to reach are the ones that depend on timing within a sequence. Two examples are a write landing while the sector window is still open, and a write landing in the middle of an engine run. Either one needs the whole six-write prefix first. The bench drives complete sequences and keeps the write spacing short enough that extra sector writes arrive before the window expires. On top of that it issues full command sequences during a running erase. A random phase follows a bench-side model of the command states. Most of the time it picks the write that continues the current sequence, so long valid sequences, corrupted sequences and bypass entry and exit occur often.

// File: rtl/eraseCmdPkg.sv
package eraseCmdPkg;

  localparam int CMD_BITS = 11;
  localparam int DATA_W   = 8;

  localparam logic [CMD_BITS-1:0] ADR_FIRST  = 11'h555;
  localparam logic [CMD_BITS-1:0] ADR_SECOND = 11'h2AA;

  localparam logic [DATA_W-1:0] CODE_KEY_A   = 8'hAA;
  localparam logic [DATA_W-1:0] CODE_KEY_B   = 8'h55;
  localparam logic [DATA_W-1:0] CODE_ARM     = 8'h80;
  localparam logic [DATA_W-1:0] CODE_ALL     = 8'h10;
  localparam logic [DATA_W-1:0] CODE_SECTOR  = 8'h30;
  localparam logic [DATA_W-1:0] CODE_BP_IN   = 8'h20;
  localparam logic [DATA_W-1:0] CODE_BP_OUT1 = 8'h90;
  localparam logic [DATA_W-1:0] CODE_BP_OUT2 = 8'h00;

  typedef enum logic [3:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_KEY3,
    ST_KEY4,
    ST_BP_ARMED,
    ST_BP_LEAVE,
    ST_COLLECT,
    ST_ERASING
  } cmdState_e;

  typedef struct packed {
    logic clrMask;
    logic setAll;
    logic addSect;
    logic loadWin;
    logic startErase;
  } dpCtrl_t;

endpackage

// File: rtl/eraseDatapath.sv
module eraseDatapath
  import eraseCmdPkg::*;
#(
  parameter int NSECT     = 8,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 30,
  localparam int SECT_BITS = $clog2(NSECT),
  localparam int ADDR_W    = CMD_BITS + SECT_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwRstN,
  input  logic                weN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busData,
  input  dpCtrl_t             ctrl,
  output logic                wrStrobe,
  output logic [CMD_BITS-1:0] wrCmdAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                eraseZero,
  output logic                winZero,
  output logic [NSECT-1:0]    sectMask
);

  localparam int ECW = $clog2(ERASE_CYC + 1);
  localparam int WCW = $clog2(WIN_CYC + 1);
  localparam logic [ECW-1:0] ERASE_LOAD = ECW'(ERASE_CYC - 1);
  localparam logic [WCW-1:0] WIN_LOAD   = WCW'(WIN_CYC - 1);

  logic [2:0]           weSync;
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic [SECT_BITS-1:0] wrSect;
  logic [NSECT-1:0]     sectHit;
  logic [ECW-1:0]       eraseCnt;
  logic [WCW-1:0]       winCnt;

  // Two-flop synchroniser plus one stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weSync <= 3'b111;
    else       weSync <= {weSync[1:0], weN};
  end

  assign wrStrobe = weSync[1] & ~weSync[2];

  // Bus is held stable by the host around the strobe release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= busAddr;
      dataQ <= busData;
    end
  end

  assign wrCmdAddr = addrQ[CMD_BITS-1:0];
  assign wrSect    = addrQ[ADDR_W-1:CMD_BITS];
  assign wrData    = dataQ;

  for (genvar i = 0; i < NSECT; i++) begin : gHit
    assign sectHit[i] = (wrSect == SECT_BITS'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sectMask <= '0;
    else if (!hwRstN || ctrl.clrMask)   sectMask <= '0;
    else if (ctrl.setAll)               sectMask <= '1;
    else if (ctrl.addSect)              sectMask <= sectMask | sectHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 eraseCnt <= '0;
    else if (!hwRstN)          eraseCnt <= '0;
    else if (ctrl.startErase)  eraseCnt <= ERASE_LOAD;
    else if (eraseCnt != '0)   eraseCnt <= eraseCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               winCnt <= '0;
    else if (!hwRstN)        winCnt <= '0;
    else if (ctrl.loadWin)   winCnt <= WIN_LOAD;
    else if (winCnt != '0)   winCnt <= winCnt - 1'b1;
  end

  assign eraseZero = (eraseCnt == '0);
  assign winZero   = (winCnt == '0);

endmodule

// File: rtl/eraseControl.sv
module eraseControl
  import eraseCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwRstN,
  input  logic                wrStrobe,
  input  logic [CMD_BITS-1:0] wrCmdAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                eraseZero,
  input  logic                winZero,
  output dpCtrl_t             ctrl,
  output logic                busy,
  output logic                pending,
  output logic                bypassOn,
  output logic                eraseDone
);

  cmdState_e state, stateNxt;
  logic      bypassNxt;
  logic      doneNxt;

  function automatic logic isCmd(input logic [CMD_BITS-1:0] a, input logic [DATA_W-1:0] d,
                                 input logic [CMD_BITS-1:0] ea, input logic [DATA_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    stateNxt  = state;
    bypassNxt = bypassOn;
    doneNxt   = 1'b0;
    ctrl      = '0;
    unique case (state)
      ST_READ: begin
        if (wrStrobe) begin
          if (bypassOn) begin
            if (wrData == CODE_ARM)          stateNxt = ST_BP_ARMED;
            else if (wrData == CODE_BP_OUT1) stateNxt = ST_BP_LEAVE;
          end else if (isCmd(wrCmdAddr, wrData, ADR_FIRST, CODE_KEY_A)) begin
            stateNxt = ST_KEY1;
          end
        end
      end
      ST_KEY1, ST_KEY3: begin
        if (wrStrobe) begin
          if (isCmd(wrCmdAddr, wrData, ADR_SECOND, CODE_KEY_B))
            stateNxt = (state == ST_KEY1) ? ST_KEY2 : ST_KEY4;
          else
            stateNxt = ST_READ;
        end
      end
      ST_KEY2: begin
        if (wrStrobe) begin
          if (isCmd(wrCmdAddr, wrData, ADR_FIRST, CODE_ARM)) begin
            stateNxt = ST_ARMED;
          end else if (isCmd(wrCmdAddr, wrData, ADR_FIRST, CODE_BP_IN)) begin
            stateNxt  = ST_READ;
            bypassNxt = 1'b1;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_ARMED: begin
        if (wrStrobe)
          stateNxt = isCmd(wrCmdAddr, wrData, ADR_FIRST, CODE_KEY_A) ? ST_KEY3 : ST_READ;
      end
      ST_KEY4, ST_BP_ARMED: begin
        if (wrStrobe) begin
          if (wrData == CODE_ALL && (state == ST_BP_ARMED || wrCmdAddr == ADR_FIRST)) begin
            ctrl.setAll     = 1'b1;
            ctrl.startErase = 1'b1;
            stateNxt        = ST_ERASING;
          end else if (wrData == CODE_SECTOR) begin
            ctrl.addSect = 1'b1;
            ctrl.loadWin = 1'b1;
            stateNxt     = ST_COLLECT;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_BP_LEAVE: begin
        if (wrStrobe) begin
          stateNxt = ST_READ;
          if (wrData == CODE_BP_OUT2) bypassNxt = 1'b0;
        end
      end
      ST_COLLECT: begin
        if (wrStrobe) begin
          if (wrData == CODE_SECTOR) begin
            ctrl.addSect = 1'b1;
            ctrl.loadWin = 1'b1;
          end else begin
            ctrl.clrMask = 1'b1;
            stateNxt     = ST_READ;
          end
        end else if (winZero) begin
          ctrl.startErase = 1'b1;
          stateNxt        = ST_ERASING;
        end
      end
      ST_ERASING: begin
        if (eraseZero) begin
          ctrl.clrMask = 1'b1;
          doneNxt      = 1'b1;
          stateNxt     = ST_READ;
        end
      end
      default: stateNxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READ;
      bypassOn  <= 1'b0;
      eraseDone <= 1'b0;
    end else if (!hwRstN) begin
      state     <= ST_READ;
      bypassOn  <= 1'b0;
      eraseDone <= 1'b0;
    end else begin
      state     <= stateNxt;
      bypassOn  <= bypassNxt;
      eraseDone <= doneNxt;
    end
  end

  assign busy    = (state == ST_ERASING);
  assign pending = (state == ST_COLLECT);

endmodule

// File: rtl/eraseCmdDecoder.sv
module eraseCmdDecoder
  import eraseCmdPkg::*;
#(
  parameter int NSECT     = 8,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 30,
  localparam int SECT_BITS = $clog2(NSECT),
  localparam int ADDR_W    = CMD_BITS + SECT_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwRstN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  output logic              busy,
  output logic              pending,
  output logic              bypassOn,
  output logic              eraseDone,
  output logic [NSECT-1:0]  sectMask
);

  dpCtrl_t             ctrl;
  logic                wrStrobe;
  logic [CMD_BITS-1:0] wrCmdAddr;
  logic [DATA_W-1:0]   wrData;
  logic                eraseZero;
  logic                winZero;

  eraseDatapath #(
    .NSECT(NSECT), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hwRstN(hwRstN), .weN(weN),
    .busAddr(busAddr), .busData(busData), .ctrl(ctrl),
    .wrStrobe(wrStrobe), .wrCmdAddr(wrCmdAddr), .wrData(wrData),
    .eraseZero(eraseZero), .winZero(winZero), .sectMask(sectMask)
  );

  eraseControl u_ctl (
    .clk(clk), .rstN(rstN), .hwRstN(hwRstN),
    .wrStrobe(wrStrobe), .wrCmdAddr(wrCmdAddr), .wrData(wrData),
    .eraseZero(eraseZero), .winZero(winZero), .ctrl(ctrl),
    .busy(busy), .pending(pending), .bypassOn(bypassOn), .eraseDone(eraseDone)
  );

endmodule

// File: rtl/eraseCmdChecker.sv
module eraseCmdChecker #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hwRstN,
  input logic             busy,
  input logic             pending,
  input logic             bypassOn,
  input logic             eraseDone,
  input logic [NSECT-1:0] sectMask
);

  assert_hw_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hwRstN |=> (!busy && !pending && !bypassOn && !eraseDone && sectMask == '0));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && pending));

  assert_mask_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(sectMask));

  assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |-> (!busy && sectMask == '0 && $past(busy)));

  assert_target_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy || pending) |-> (sectMask != '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |=> !eraseDone);

endmodule

bind eraseCmdDecoder eraseCmdChecker #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rstN(rstN), .hwRstN(hwRstN), .busy(busy), .pending(pending),
  .bypassOn(bypassOn), .eraseDone(eraseDone), .sectMask(sectMask)
);

// File: tb/eraseCmdDecoder_bench.sv
module eraseCmdDecoder_bench;

  localparam int NSECT = 8;
  localparam int ECYC  = 40;
  localparam int WCYC  = 30;
  localparam int AW    = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwRstN = 1'b1;
  logic weN = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic busy, pending, bypassOn, eraseDone;
  logic [NSECT-1:0] sectMask;

  int nChk = 0;
  int nBad = 0;
  int busyRun = 0;
  int lastRun = 0;
  int doneCnt = 0;

  // model of the command state
  int mSt = 0;
  bit mBp = 1'b0;
  logic [NSECT-1:0] mMask = '0;

  always #5 clk = ~clk;

  eraseCmdDecoder #(.NSECT(NSECT), .ERASE_CYC(ECYC), .WIN_CYC(WCYC)) u_eraseCmdDecoder (
    .clk(clk), .rstN(rstN), .hwRstN(hwRstN), .weN(weN), .busAddr(busAddr),
    .busData(busData), .busy(busy), .pending(pending), .bypassOn(bypassOn),
    .eraseDone(eraseDone), .sectMask(sectMask)
  );

  always @(negedge clk) begin
    if (busy) busyRun++;
    else begin
      if (busyRun != 0) lastRun = busyRun;
      busyRun = 0;
    end
    if (eraseDone) doneCnt++;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input logic [2:0] s, input logic [10:0] low);
    return {s, low};
  endfunction

  task automatic busWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busData = d; weN = 1'b0;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic prefix();
    busWrite(adr(3'($urandom), 11'h555), 8'hAA);
    busWrite(adr(3'($urandom), 11'h2AA), 8'h55);
    busWrite(adr(3'($urandom), 11'h555), 8'h80);
    busWrite(adr(3'($urandom), 11'h555), 8'hAA);
    busWrite(adr(3'($urandom), 11'h2AA), 8'h55);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy && !pending) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // expected next state for one write
  function automatic void mdlStep(input logic [AW-1:0] a, input logic [7:0] d);
    logic [10:0] lo = a[10:0];
    logic [NSECT-1:0] hit = NSECT'(1) << a[13:11];
    case (mSt)
      0: if (mBp) begin
           if (d == 8'h80) mSt = 6; else if (d == 8'h90) mSt = 7;
         end else if (lo == 11'h555 && d == 8'hAA) mSt = 1;
      1: mSt = (lo == 11'h2AA && d == 8'h55) ? 2 : 0;
      2: begin
           if (lo == 11'h555 && d == 8'h80) mSt = 3;
           else begin
             if (lo == 11'h555 && d == 8'h20) mBp = 1'b1;
             mSt = 0;
           end
         end
      3: mSt = (lo == 11'h555 && d == 8'hAA) ? 4 : 0;
      4: mSt = (lo == 11'h2AA && d == 8'h55) ? 5 : 0;
      5, 6: begin
           if (d == 8'h10 && (mSt == 6 || lo == 11'h555)) begin mSt = 9; mMask = '1; end
           else if (d == 8'h30) begin mSt = 8; mMask = hit; end
           else mSt = 0;
         end
      7: begin if (d == 8'h00) mBp = 1'b0; mSt = 0; end
      default: mSt = 0;
    endcase
  endfunction

  task automatic goodWrite(output logic [AW-1:0] a, output logic [7:0] d);
    logic [2:0] s = 3'($urandom);
    a = adr(s, 11'($urandom));
    case (mSt)
      0: if (mBp) d = ($urandom % 2) ? 8'h80 : 8'h90;
         else begin a = adr(s, 11'h555); d = 8'hAA; end
      1, 4: begin a = adr(s, 11'h2AA); d = 8'h55; end
      2: begin a = adr(s, 11'h555); d = ($urandom % 3 == 0) ? 8'h20 : 8'h80; end
      3: begin a = adr(s, 11'h555); d = 8'hAA; end
      5: begin d = ($urandom % 2) ? 8'h30 : 8'h10; if (d == 8'h10) a = adr(s, 11'h555); end
      6: d = ($urandom % 2) ? 8'h30 : 8'h10;
      default: d = 8'h00;
    endcase
  endtask

  task automatic randomWrite(output logic [AW-1:0] a, output logic [7:0] d);
    logic [7:0] pool [9] = '{8'hAA, 8'h55, 8'h80, 8'h10, 8'h20, 8'h90, 8'h00, 8'h30, 8'hF0};
    logic [10:0] lows [3] = '{11'h555, 11'h2AA, 11'h123};
    d = pool[$urandom % 9];
    a = adr(3'($urandom), lows[$urandom % 3]);
  endtask

  initial begin
    int d0;
    logic [AW-1:0] ra;
    logic [7:0] rd;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pending", pending, 0);
    chk("R1 bypass", bypassOn, 0);
    chk("R1 done", eraseDone, 0);
    chk("R1 mask", sectMask, 0);

    // R2 whole-array erase, R6 writes while busy
    d0 = doneCnt;
    prefix();
    busWrite(adr(3'd0, 11'h555), 8'h10);
    chk("R2 busy", busy, 1);
    chk("R2 mask", sectMask, 8'hFF);
    busWrite(adr(3'd0, 11'h555), 8'hAA);
    busWrite(adr(3'd0, 11'h2AA), 8'h55);
    busWrite(adr(3'd2, 11'h555), 8'h30);
    chk("R6 mask kept", sectMask, 8'hFF);
    waitIdle();
    chk("R7 run length", lastRun, ECYC);
    chk("R7 one done", doneCnt - d0, 1);
    chk("R7 mask cleared", sectMask, 0);
    repeat (60) @(negedge clk);
    chk("R6 nothing after", busy | pending, 0);

    // R3 single sector
    prefix();
    busWrite(adr(3'd5, 11'h0F0), 8'h30);
    chk("R3 pending", pending, 1);
    chk("R3 mask", sectMask, 8'h20);
    waitIdle();
    chk("R3 erase ran", lastRun, ECYC);

    // R4 add sectors, then cancel
    prefix();
    busWrite(adr(3'd2, 11'h001), 8'h30);
    busWrite(adr(3'd6, 11'h7FF), 8'h30);
    busWrite(adr(3'd2, 11'h555), 8'h30);
    chk("R4 mask merged", sectMask, 8'h44);
    chk("R4 still pending", pending, 1);
    waitIdle();
    chk("R4 merged erase ran", lastRun, ECYC);
    d0 = doneCnt;
    prefix();
    busWrite(adr(3'd1, 11'h000), 8'h30);
    busWrite(adr(3'd1, 11'h000), 8'hF0);
    chk("R4 cancel pending", pending, 0);
    chk("R4 cancel mask", sectMask, 0);
    repeat (80) @(negedge clk);
    chk("R4 no erase", busy, 0);
    chk("R4 no done", doneCnt - d0, 0);

    // R5 bypass mode
    busWrite(adr(3'd0, 11'h555), 8'hAA);
    busWrite(adr(3'd0, 11'h2AA), 8'h55);
    busWrite(adr(3'd0, 11'h555), 8'h20);
    chk("R5 bypass on", bypassOn, 1);
    busWrite(adr(3'd4, 11'h321), 8'h80);
    busWrite(adr(3'd4, 11'h321), 8'h10);
    chk("R5 short chip erase", busy, 1);
    chk("R5 short chip mask", sectMask, 8'hFF);
    waitIdle();
    busWrite(adr(3'd3, 11'h000), 8'h80);
    busWrite(adr(3'd3, 11'h000), 8'h30);
    chk("R5 short sector", sectMask, 8'h08);
    waitIdle();
    chk("R5 bypass kept", bypassOn, 1);
    busWrite(adr(3'd0, 11'h000), 8'h90);
    busWrite(adr(3'd0, 11'h000), 8'h00);
    chk("R5 bypass off", bypassOn, 0);
    busWrite(adr(3'd0, 11'h555), 8'h80);
    busWrite(adr(3'd0, 11'h555), 8'h10);
    chk("R5 short ignored after exit", busy, 0);

    // R9 broken sequences
    busWrite(adr(3'd0, 11'h555), 8'hAA);
    busWrite(adr(3'd0, 11'h2AA), 8'h55);
    busWrite(adr(3'd0, 11'h555), 8'h80);
    busWrite(adr(3'd0, 11'h555), 8'hAA);
    busWrite(adr(3'd0, 11'h555), 8'h12);
    busWrite(adr(3'd0, 11'h555), 8'h10);
    chk("R9 broken no busy", busy | pending, 0);
    prefix();
    busWrite(adr(3'd0, 11'h555), 8'h10);
    chk("R9 recovery", busy, 1);
    waitIdle();

    // R10 strobe held low
    prefix();
    @(negedge clk);
    busAddr = adr(3'd0, 11'h555); busData = 8'h10; weN = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 held low", busy, 0);
    weN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 rising edge", busy, 1);
    waitIdle();

    // R8 hardware reset
    d0 = doneCnt;
    prefix();
    busWrite(adr(3'd0, 11'h555), 8'h10);
    repeat (10) @(negedge clk);
    hwRstN = 1'b0;
    @(negedge clk);
    chk("R8 busy cut", busy, 0);
    chk("R8 mask cut", sectMask, 0);
    hwRstN = 1'b1;
    repeat (60) @(negedge clk);
    chk("R8 no done", doneCnt - d0, 0);
    busWrite(adr(3'd0, 11'h555), 8'hAA);
    busWrite(adr(3'd0, 11'h2AA), 8'h55);
    busWrite(adr(3'd0, 11'h555), 8'h20);
    busWrite(adr(3'd7, 11'h000), 8'h80);
    busWrite(adr(3'd7, 11'h000), 8'h30);
    hwRstN = 1'b0;
    @(negedge clk);
    chk("R8 pending cut", pending, 0);
    chk("R8 bypass cut", bypassOn, 0);
    hwRstN = 1'b1;
    repeat (40) @(negedge clk);

    // random phase against the model (R2 R3 R5 R9)
    mSt = 0; mBp = 1'b0; mMask = '0;
    for (int it = 0; it < 120; it++) begin
      if ($urandom % 4 != 0) goodWrite(ra, rd);
      else randomWrite(ra, rd);
      mdlStep(ra, rd);
      busWrite(ra, rd);
      chk("R9 random busy", busy, (mSt == 9));
      chk("R9 random pending", pending, (mSt == 8));
      chk("R5 random bypass", bypassOn, mBp);
      if (mSt == 8 || mSt == 9) begin
        chk("R3 random mask", sectMask, mMask);
        waitIdle();
        chk("R7 random run", lastRun, ECYC);
        mSt = 0; mMask = '0;
      end
    end

    summary();
  end

endmodule